// File: doc/BRIEF.md
# Programmable Interval Timer

A three-channel interval timer reached over a byte-wide bus with four addresses. Addresses 0, 1 and 2 read and write the count of channels 0, 1 and 2; address 3 accepts a control word that targets one channel. The control word either freezes that channel's count for a stable readout, or sets how the channel's 16-bit count is moved over the 8-bit bus, which mode it runs in, and whether it counts in binary or in four BCD digits.

Each channel is a down counter that moves once per clock once a full count has been written. In the rate-generator mode its output drops for one clock per period. In the square-wave mode the output is high for the larger half of the period. All other modes behave as a terminal-count timer: the output stays low until the count passes from 1 to 0, then stays high. The output period in the periodic modes equals the loaded count. Software picks the count as the clock frequency divided by the wanted frequency, rounded to the nearest integer.

Top module: `interval_timer`

## Requirements
- R1: After reset every channel output is low, every channel is in mode 0, binary, low-byte-only access, and a read of addresses 0 to 2 returns 0.
- R2: A write to address 3 decodes bits 7:6 as the channel (0, 1, 2; the value 3 changes no channel), bits 5:4 as access (0 latch, 1 low byte only, 2 high byte only, 3 low then high), bits 3:1 as mode, and bit 0 as BCD (1) or binary (0). Modes 6 and 7 act as modes 2 and 3.
- R3: With low-only access a count write loads {0, byte}; with high-only access it loads {byte, 0}; with low-then-high access the first write holds the low byte and the second loads {byte, held}. The counter takes the new count on the clock edge of the completing write. A non-latch control word resets the write byte order to low and stops the channel until a count is written.
- R4: A read returns the low byte for low-only access, the high byte for high-only access, and alternately low then high for low-then-high access, using a byte order separate from the write side. A non-latch control word resets the read byte order to low.
- R5: A latch command captures the count held before that clock edge. Reads then return the captured value, in the programmed byte order, while counting continues. A further latch command is ignored until the captured value has been read in full.
- R6: In the terminal-count modes the output goes low on the control word and on a count load, goes high on the edge where the count passes from 1 to 0, and stays high until the next control word or load.
- R7: In the rate-generator mode the output is low exactly while the count equals 1, and on the next edge the count reloads, giving a period equal to the loaded count.
- R8: In the square-wave mode with loaded count N, the output is high while the count is above N/2 (rounded down) and low otherwise, so an odd N gives the high half one extra clock.
- R9: A loaded count of 0 stands for 65536 in binary and 10000 in BCD. Counting wraps from 0 to 65535 in binary and from 0000 to 9999 in BCD, and BCD counting borrows per decimal digit.
- R10: A read of address 3 returns 0. A read asserted together with a write is ignored and moves no byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters move once per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Bus address: 0..2 channel count, 3 control |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed location |
| chanOut | output | 3 | One output per channel |

## Verification
A latch command and a channel's reload or terminal-count step can fall on the same clock edge. The latch must capture the count held before that edge while the counter moves on. The bench provokes this by issuing latch commands at every offset within a short rate-generator period and reading the captured value back byte by byte. Each read and every output is compared, cycle by cycle, against a behavioural model that updates its own integer state after each edge. A count write that completes on a reload edge is judged the same way: the new count must win over the reload.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int COUNT_W  = 16;
  localparam int DIGITS   = COUNT_W / 4;
  localparam int NUM_CHAN = 3;
  localparam int BCD_SPAN = 10 ** DIGITS;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } accessT;

  // Strobes and levels from a channel's control slice to its counter slice
  typedef struct packed {
    logic               reprogram;
    logic               loadCount;
    logic               capture;
    logic [COUNT_W-1:0] loadValue;
    logic [2:0]         mode;
    logic               bcd;
  } chanStrobeT;

  // One step down, binary or per-digit BCD with borrow
  function automatic logic [COUNT_W-1:0] decCount(input logic [COUNT_W-1:0] v,
                                                  input logic bcd);
    logic [COUNT_W-1:0] r;
    logic borrow;
    if (!bcd) return v - 1'b1;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Numeric length of a count value, with zero meaning the full span
  function automatic logic [COUNT_W:0] spanOf(input logic [COUNT_W-1:0] v,
                                              input logic bcd);
    logic [COUNT_W:0] acc;
    if (v == '0) return bcd ? (COUNT_W+1)'(BCD_SPAN) : {1'b1, {COUNT_W{1'b0}}};
    if (!bcd) return {1'b0, v};
    acc = '0;
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = acc * (COUNT_W+1)'(10) + (COUNT_W+1)'(v[d*4 +: 4]);
    return acc;
  endfunction
endpackage

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [7:0]         wrData,
  input  logic [COUNT_W-1:0] liveCount,
  input  logic [COUNT_W-1:0] heldCount,
  output chanStrobeT         strb,
  output logic [7:0]         rdByte
);
  localparam logic [1:0] MY_ID   = 2'(CHAN_ID);
  localparam logic [1:0] CTL_ADR = 2'd3;

  logic        ctlHit, isLatchCmd, cntWrHit, cntRdHit, readDone, takeHigh;
  accessT      accReg;
  logic [2:0]  modeReg;
  logic        bcdReg, wrHiNext, rdHiNext, latPend;
  logic [7:0]  loHold;
  logic [COUNT_W-1:0] srcVal;

  always_comb begin
    ctlHit     = busWr && (busAddr == CTL_ADR) && (wrData[7:6] == MY_ID);
    isLatchCmd = ctlHit && (accessT'(wrData[5:4]) == ACC_LATCH);
    cntWrHit   = busWr && (busAddr == MY_ID);
    cntRdHit   = busRd && !busWr && (busAddr == MY_ID);

    strb.reprogram = ctlHit && !isLatchCmd;
    strb.capture   = isLatchCmd && !latPend;
    strb.mode      = modeReg;
    strb.bcd       = bcdReg;
    case (accReg)
      ACC_HI: begin
        strb.loadCount = cntWrHit;
        strb.loadValue = {wrData, 8'h00};
      end
      ACC_BOTH: begin
        strb.loadCount = cntWrHit && wrHiNext;
        strb.loadValue = {wrData, loHold};
      end
      default: begin
        strb.loadCount = cntWrHit;
        strb.loadValue = {8'h00, wrData};
      end
    endcase

    takeHigh = (accReg == ACC_HI) || ((accReg == ACC_BOTH) && rdHiNext);
    srcVal   = latPend ? heldCount : liveCount;
    rdByte   = takeHigh ? srcVal[15:8] : srcVal[7:0];
    readDone = cntRdHit && ((accReg != ACC_BOTH) || rdHiNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= ACC_LO;
      modeReg  <= 3'd0;
      bcdReg   <= 1'b0;
      wrHiNext <= 1'b0;
      rdHiNext <= 1'b0;
      latPend  <= 1'b0;
      loHold   <= 8'h00;
    end else if (strb.reprogram) begin
      accReg   <= accessT'(wrData[5:4]);
      modeReg  <= wrData[3:1];
      bcdReg   <= wrData[0];
      wrHiNext <= 1'b0;
      rdHiNext <= 1'b0;
      latPend  <= 1'b0;
    end else begin
      if (cntWrHit && accReg == ACC_BOTH) begin
        wrHiNext <= !wrHiNext;
        if (!wrHiNext) loHold <= wrData;
      end
      if (cntRdHit && accReg == ACC_BOTH) rdHiNext <= !rdHiNext;
      if (strb.capture) latPend <= 1'b1;
      else if (readDone) latPend <= 1'b0;
    end
  end

  // R5: while a capture waits to be read, the counter slice keeps it frozen
  assert_latch_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    latPend |=> $stable(heldCount));
endmodule

// File: rtl/itimer_count.sv
module itimer_count
  import itimer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  chanStrobeT         strb,
  output logic [COUNT_W-1:0] liveCount,
  output logic [COUNT_W-1:0] heldCount,
  output logic               chanOut
);
  logic [COUNT_W-1:0] cntReg, reloadReg, latchReg;
  logic               armed, tcFlag, periodic, atOne;
  logic [2:0]         modeEff;

  always_comb begin
    modeEff  = (strb.mode[2:1] == 2'b11) ? {1'b0, strb.mode[1:0]} : strb.mode;
    periodic = (modeEff == 3'd2) || (modeEff == 3'd3);
    atOne    = (cntReg == COUNT_W'(1));
    case (modeEff)
      3'd2:    chanOut = !armed || !atOne;
      3'd3:    chanOut = !armed ||
                         (spanOf(cntReg, strb.bcd) > (spanOf(reloadReg, strb.bcd) >> 1));
      default: chanOut = tcFlag;
    endcase
    liveCount = cntReg;
    heldCount = latchReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg    <= '0;
      reloadReg <= '0;
      latchReg  <= '0;
      armed     <= 1'b0;
      tcFlag    <= 1'b0;
    end else begin
      if (strb.capture) latchReg <= cntReg;
      if (strb.loadCount) begin
        cntReg    <= strb.loadValue;
        reloadReg <= strb.loadValue;
        armed     <= 1'b1;
        tcFlag    <= 1'b0;
      end else if (strb.reprogram) begin
        armed  <= 1'b0;
        tcFlag <= 1'b0;
      end else if (armed) begin
        if (periodic && atOne) cntReg <= reloadReg;
        else cntReg <= decCount(cntReg, strb.bcd);
        if (!periodic && atOne) tcFlag <= 1'b1;
      end
    end
  end

  // R6: a reached terminal count keeps the output high
  assert_tc_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed && !periodic && tcFlag && !strb.loadCount && !strb.reprogram |=> chanOut);

  // R7: the rate-generator low pulse lasts a single clock
  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed && modeEff == 3'd2 && !chanOut && reloadReg != COUNT_W'(1)
      && !strb.loadCount && !strb.reprogram |=> chanOut);

  // R9: a running channel never stalls (wrap and reload included)
  assert_count_moves_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed && !strb.loadCount && !strb.reprogram && reloadReg != COUNT_W'(1)
      |=> cntReg != $past(cntReg));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  output logic [NUM_CHAN-1:0] chanOut
);
  chanStrobeT         strbArr [NUM_CHAN];
  logic [COUNT_W-1:0] liveArr [NUM_CHAN];
  logic [COUNT_W-1:0] heldArr [NUM_CHAN];
  logic [7:0]         byteArr [NUM_CHAN];
  logic [NUM_CHAN-1:0] reprogVec;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gChan
    itimer_ctrl #(.CHAN_ID(g)) uCtrl (
      .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
      .wrData(wrData), .liveCount(liveArr[g]), .heldCount(heldArr[g]),
      .strb(strbArr[g]), .rdByte(byteArr[g])
    );
    itimer_count uCount (
      .clk(clk), .rstN(rstN), .strb(strbArr[g]),
      .liveCount(liveArr[g]), .heldCount(heldArr[g]), .chanOut(chanOut[g])
    );
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_CHAN; i++)
      if (busAddr == 2'(i)) rdData = byteArr[i];
    for (int i = 0; i < NUM_CHAN; i++)
      reprogVec[i] = strbArr[i].reprogram;
  end

  // R2: a control word reaches at most one channel
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reprogVec));
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic       clk = 1'b0, rstN = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [2:0] chanOut;

  interval_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .wrData(wrData), .rdData(rdData), .chanOut(chanOut)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  string phaseTag = "";

  // behavioural state, numeric counts
  int mMode[3], mAcc[3], mBcd[3], mArmed[3], mCnt[3], mRel[3];
  int mWrHi[3], mLoHold[3], mRdHi[3], mLat[3], mLatP[3], mTc[3];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int c = 0; c < 3; c++) begin
      mMode[c] = 0; mAcc[c] = 1; mBcd[c] = 0; mArmed[c] = 0; mCnt[c] = 0; mRel[c] = 0;
      mWrHi[c] = 0; mLoHold[c] = 0; mRdHi[c] = 0; mLat[c] = 0; mLatP[c] = 0; mTc[c] = 0;
    end
  endfunction

  function automatic int modeOf(int c);
    return (mMode[c] >= 6) ? mMode[c] - 4 : mMode[c];
  endfunction

  function automatic int rawOf(int v, int bcd);
    if (bcd == 0) return v;
    return (((v / 1000) % 10) << 12) | (((v / 100) % 10) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  function automatic int valOf(int raw, int bcd);
    if (bcd == 0) return raw;
    return ((raw >> 12) & 15) * 1000 + ((raw >> 8) & 15) * 100 + ((raw >> 4) & 15) * 10 + (raw & 15);
  endfunction

  function automatic int effOf(int v, int bcd);
    if (v != 0) return v;
    return (bcd != 0) ? 10000 : 65536;
  endfunction

  function automatic int expOut(int c);
    int m = modeOf(c);
    if (m == 2) return (mArmed[c] == 0 || mCnt[c] != 1) ? 1 : 0;
    if (m == 3) return (mArmed[c] == 0 || effOf(mCnt[c], mBcd[c]) > effOf(mRel[c], mBcd[c]) / 2) ? 1 : 0;
    return mTc[c];
  endfunction

  function automatic int expRead(int addr);
    int src, raw;
    bit hi;
    if (addr == 3) return 0;
    src = (mLatP[addr] != 0) ? mLat[addr] : mCnt[addr];
    raw = rawOf(src, mBcd[addr]);
    hi = (mAcc[addr] == 2) || (mAcc[addr] == 3 && mRdHi[addr] != 0);
    return hi ? ((raw >> 8) & 255) : (raw & 255);
  endfunction

  function automatic string outTag(int c);
    int m = modeOf(c);
    if (m == 2) return "R7";
    if (m == 3) return "R8";
    return "R6";
  endfunction

  function automatic string readTag(int addr);
    if (phaseTag != "") return phaseTag;
    if (addr == 3) return "R10";
    if (mLatP[addr] != 0) return "R5";
    return "R4";
  endfunction

  function automatic void modelUpdate(bit wr, bit rd, int addr, int data);
    for (int c = 0; c < 3; c++) begin
      bit ctl   = wr && addr == 3 && ((data >> 6) & 3) == c;
      bit latch = ctl && ((data >> 4) & 3) == 0;
      bit reprog = ctl && !latch;
      bit cw = wr && addr == c;
      bit cr = rd && !wr && addr == c;
      bit load = 0;
      int raw = 0;
      int m = modeOf(c);
      if (latch && mLatP[c] == 0) begin
        mLat[c] = mCnt[c];
        mLatP[c] = 1;
      end
      if (cr) begin
        if (mAcc[c] == 3) begin
          if (mRdHi[c] != 0) mLatP[c] = 0;
          mRdHi[c] = 1 - mRdHi[c];
        end else mLatP[c] = 0;
      end
      if (reprog) begin
        mAcc[c] = (data >> 4) & 3; mMode[c] = (data >> 1) & 7; mBcd[c] = data & 1;
        mArmed[c] = 0; mTc[c] = 0; mWrHi[c] = 0; mRdHi[c] = 0; mLatP[c] = 0;
      end else if (cw) begin
        if (mAcc[c] == 1) begin load = 1; raw = data; end
        else if (mAcc[c] == 2) begin load = 1; raw = data << 8; end
        else if (mWrHi[c] == 0) begin mLoHold[c] = data; mWrHi[c] = 1; end
        else begin load = 1; raw = (data << 8) | mLoHold[c]; mWrHi[c] = 0; end
      end
      if (load) begin
        mCnt[c] = valOf(raw, mBcd[c]); mRel[c] = mCnt[c]; mArmed[c] = 1; mTc[c] = 0;
      end else if (!reprog && mArmed[c] != 0) begin
        if ((m == 2 || m == 3) && mCnt[c] == 1) mCnt[c] = mRel[c];
        else begin
          if (mCnt[c] == 1) mTc[c] = 1;
          mCnt[c] = (mCnt[c] == 0) ? ((mBcd[c] != 0) ? 9999 : 65535) : mCnt[c] - 1;
        end
      end
    end
  endfunction

  task automatic step(bit wr, bit rd, int addr, int data);
    busWr = wr; busRd = rd; busAddr = addr[1:0]; wrData = data[7:0];
    #1;
    for (int c = 0; c < 3; c++) chk(outTag(c), int'(chanOut[c]), expOut(c));
    if (rd && !wr) chk(readTag(addr), int'(rdData), expRead(addr));
    @(posedge clk);
    modelUpdate(wr, rd, addr, data);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask
  task automatic wrB(int addr, int data); step(1, 0, addr, data); endtask
  task automatic rdB(int addr); step(0, 1, addr, 0); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R1", int'(chanOut), 0);
    rstN = 1'b1;
    // R1: reset state through the bus
    phaseTag = "R1";
    rdB(0); rdB(1); rdB(2);
    // R3: byte sequencing on writes, three channels started
    phaseTag = "R3";
    wrB(3, 8'h34); wrB(0, 5); wrB(0, 0);
    wrB(3, 8'h76); wrB(1, 7); wrB(1, 0);
    wrB(3, 8'hB0); wrB(2, 3); wrB(2, 0);
    idle(30);
    wrB(3, 8'h54); wrB(1, 8'h09); rdB(1); rdB(1); idle(12);
    wrB(3, 8'h64); wrB(1, 8'h01); rdB(1); idle(10);
    // R4: alternating read bytes, reset by a control word
    phaseTag = "R4";
    wrB(3, 8'hB4); wrB(2, 8'h34); wrB(2, 8'h12);
    rdB(2); rdB(2); rdB(2); rdB(2); rdB(2);
    wrB(3, 8'hB4); rdB(2); rdB(2);
    wrB(2, 8'h00); wrB(2, 8'h01); idle(5);
    // R5: latch freezes, repeated latch ignored, latch at every offset
    phaseTag = "";
    wrB(3, 8'h00); idle(3); wrB(3, 8'h00); idle(2); rdB(0); rdB(0);
    wrB(3, 8'h40); idle(4); rdB(1); rdB(1);
    for (int k = 0; k < 7; k++) begin
      wrB(3, 8'h00); idle(k); rdB(0); rdB(0);
    end
    // R2: channel 3 select ignored, modes 6 and 7 alias, BCD square wave
    phaseTag = "R2";
    wrB(3, 8'hF4); idle(3); rdB(0); rdB(0);
    wrB(3, 8'h1E); wrB(0, 4); idle(12); rdB(0);
    wrB(3, 8'h9C); wrB(2, 3); idle(10); rdB(2);
    wrB(3, 8'h57); wrB(1, 8'h10); idle(25); rdB(1);
    // R10: control address reads zero, read with write ignored
    phaseTag = "R10";
    rdB(3);
    wrB(3, 8'hB4); wrB(2, 8'h10);
    step(1, 1, 2, 8'h00);
    rdB(2); rdB(2); idle(20);
    // R9: zero counts and wrap in binary and BCD
    phaseTag = "R9";
    wrB(3, 8'h30); wrB(0, 0); wrB(0, 0);
    wrB(3, 8'h71); wrB(1, 0); wrB(1, 0);
    wrB(3, 8'hB5); wrB(2, 0); wrB(2, 0);
    idle(5); rdB(0); rdB(0); rdB(1); rdB(1); rdB(2); rdB(2);
    for (int blk = 0; blk < 17; blk++) begin
      idle(3900);
      rdB(1); rdB(1); rdB(0); rdB(0);
    end
    idle(40);
    finished = 1;
    summary();
    $finish;
  end
endmodule